// File: doc/BRIEF.md
# CEA Extension HDMI Vendor Block Detector

This block watches a 128-byte display-identification extension block as it streams past, one byte per clock with its byte index and a valid strobe. Without buffering the block, it decides whether the extension is of the CEA-861 kind and whether its data block collection holds an HDMI vendor-specific data block. If it does, it also reports whether the sink advertises basic audio.

Bytes arrive in ascending index order, and idle cycles (valid low) may appear between them. The parser follows the data block collection on the fly. Each block header gives a tag and a payload length, and the parser uses them to find the next header. A header whose block would run past the end of the collection stops the walk. The verdict is registered and held until the next one. A one-cycle pulse marks each new verdict, and the parser then rearms itself for the next extension block.

Top module: `cea_vsdb_scan`

## Requirements
- R1: Unless byte 0 equals 0x02, the verdict is "not HDMI" and audio is reported as 0.
- R2: Byte 2 is the end offset of the data block collection; no header at an index equal to or above it is examined.
- R3: When the end offset is 4 or less, there are no data blocks and the verdict is "not HDMI".
- R4: The first header sits at index 4. A header carries its tag in bits [7:5] and its payload length in bits [4:0]. The next header sits at header index + 1 + length.
- R5: A header whose index + length + 1 is greater than the end offset ends the walk with no match. A block that ends exactly at the end offset is still accepted.
- R6: A block matches when its tag is 3, its length is at least 5, and payload bytes 1, 2 and 3 are 0x03, 0x0C and 0x00 in that order.
- R7: The audio flag equals bit 6 of byte 3 when a match was found, and is 0 otherwise.
- R8: The first match is kept, and later blocks in the same extension cannot clear or change it.
- R9: The cycle after byte 127 is accepted, result_valid pulses high for exactly one cycle. At that same edge both flags take the new verdict and then hold it. The next extension block is parsed from a clean state.
- R10: A synchronous active-high reset clears result_valid, is_hdmi and has_audio to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_idx | input | 7 | Index of the byte within the extension block |
| in_byte | input | 8 | Byte value |
| result_valid | output | 1 | One-cycle pulse when a new verdict is registered |
| is_hdmi | output | 1 | HDMI vendor block found in the last extension block |
| has_audio | output | 1 | Basic audio advertised, valid only together with is_hdmi |

## Verification
Any fault in the walker or the matcher stays hidden until the verdict edge that follows byte 127. There it shows up as a wrong is_hdmi or has_audio value, held for the whole next frame, so each frame gives only one observation point. For that reason, every frame is built to put a single corner of the walk on that point: a header that points one byte past the end, a block that ends exactly at the end offset, a short vendor block, a wrong OUI order, or a match that comes after skipped blocks. A reference model compares the pulse and the flags on every clock, so a mistimed or doubled pulse shows up on the cycle it happens.

// File: rtl/cea_scan_pkg.sv
package cea_scan_pkg;
  localparam int TAG_W = 3;
  localparam int LEN_W = 5;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [LEN_W-1:0] len;
  } blk_hdr_t;
endpackage

// File: rtl/cea_hdr_walker.sv
module cea_hdr_walker
  import cea_scan_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int OFF_W = 8,
  parameter int FIRST_HDR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       dat,
  input  logic             frame_end,
  input  logic             enable,
  input  logic [OFF_W-1:0] end_off,
  output logic             hdr_stb,
  output blk_hdr_t         hdr
);
  localparam int SUM_W = OFF_W + 1;

  logic [OFF_W-1:0] nxt_q;
  logic             halt_q;
  logic [OFF_W-1:0] pos;
  logic [SUM_W-1:0] blk_end;
  logic             at_hdr;
  logic             fits;

  assign pos     = OFF_W'(idx);
  assign hdr     = blk_hdr_t'(dat);
  assign blk_end = {1'b0, pos} + SUM_W'(hdr.len) + SUM_W'(1);
  assign at_hdr  = vld && enable && !halt_q && (pos == nxt_q) && (pos < end_off);
  assign fits    = blk_end <= {1'b0, end_off};
  assign hdr_stb = at_hdr && fits;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      nxt_q  <= OFF_W'(FIRST_HDR);
      halt_q <= 1'b0;
    end else if (at_hdr) begin
      if (fits) nxt_q <= blk_end[OFF_W-1:0];
      else      halt_q <= 1'b1;
    end
  end

  // R5: once the walk has halted, no header is accepted until the frame ends
  p_halt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !frame_end) |=> (halt_q && !hdr_stb));

  // R4: the header pointer only moves forward within a frame
  p_walk_forward_r4: assert property (@(posedge clk) disable iff (rst)
    (hdr_stb && !frame_end) |=> (nxt_q > $past(pos)));
endmodule

// File: rtl/cea_oui_match.sv
module cea_oui_match
  import cea_scan_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int OFF_W = 8,
  parameter int VSDB_TAG = 3,
  parameter int MIN_LEN = 5,
  parameter int OUI_BYTES = 3,
  parameter logic [8*OUI_BYTES-1:0] OUI = 24'h000C03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       dat,
  input  logic             frame_end,
  input  logic             hdr_stb,
  input  blk_hdr_t         hdr,
  output logic             found_now,
  output logic             found_q
);
  logic [OFF_W-1:0]     base_q;
  logic                 cand_q;
  logic [OFF_W-1:0]     pos;
  logic [OUI_BYTES-1:0] hit;
  logic [OUI_BYTES-1:0] ok;
  logic                 miss;
  logic                 complete;

  assign pos = OFF_W'(idx);

  for (genvar k = 0; k < OUI_BYTES; k++) begin : g_oui
    assign hit[k] = (pos == base_q + OFF_W'(k + 1));
    assign ok[k]  = (dat == OUI[8*k +: 8]);
  end

  assign miss      = vld && cand_q && |(hit & ~ok);
  assign complete  = vld && cand_q && hit[OUI_BYTES-1] && ok[OUI_BYTES-1];
  assign found_now = found_q || complete;

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      cand_q  <= 1'b0;
      found_q <= 1'b0;
      base_q  <= '0;
    end else begin
      if (complete) found_q <= 1'b1;
      if (hdr_stb && !found_now) begin
        base_q <= pos;
        cand_q <= (hdr.tag == TAG_W'(VSDB_TAG)) && (hdr.len >= LEN_W'(MIN_LEN));
      end else if (miss || complete) begin
        cand_q <= 1'b0;
      end
    end
  end

  // R8: a match stays until the frame is closed
  p_first_match_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (found_q && !frame_end) |=> found_q);

  // R6: no candidate can be opened after a match
  p_no_cand_after_match_r6: assert property (@(posedge clk) disable iff (rst)
    found_q |-> !cand_q);
endmodule

// File: rtl/cea_vsdb_scan.sv
module cea_vsdb_scan
  import cea_scan_pkg::*;
#(
  parameter int BLK_BYTES = 128,
  parameter int OFF_W = 8,
  parameter logic [7:0] EXT_TAG = 8'h02,
  parameter int TAG_IDX = 0,
  parameter int END_IDX = 2,
  parameter int FEAT_IDX = 3,
  parameter int AUDIO_BIT = 6,
  parameter int FIRST_HDR = 4,
  parameter int VSDB_TAG = 3,
  parameter int MIN_LEN = 5,
  parameter logic [23:0] OUI = 24'h000C03,
  localparam int IDX_W = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [7:0]       in_byte,
  output logic             result_valid,
  output logic             is_hdmi,
  output logic             has_audio
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  logic             tag_ok_q;
  logic [OFF_W-1:0] end_off_q;
  logic             aud_q;
  logic             frame_end;
  logic             hdr_stb;
  blk_hdr_t         hdr;
  logic             found_now;
  logic             found_q;

  assign frame_end = in_valid && (in_idx == LAST_IDX);

  cea_hdr_walker #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .FIRST_HDR(FIRST_HDR)
  ) u_walk (
    .clk(clk), .rst(rst), .vld(in_valid), .idx(in_idx), .dat(in_byte),
    .frame_end(frame_end), .enable(tag_ok_q), .end_off(end_off_q),
    .hdr_stb(hdr_stb), .hdr(hdr)
  );

  cea_oui_match #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .VSDB_TAG(VSDB_TAG), .MIN_LEN(MIN_LEN),
    .OUI_BYTES(3), .OUI(OUI)
  ) u_match (
    .clk(clk), .rst(rst), .vld(in_valid), .idx(in_idx), .dat(in_byte),
    .frame_end(frame_end), .hdr_stb(hdr_stb), .hdr(hdr),
    .found_now(found_now), .found_q(found_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_ok_q     <= 1'b0;
      end_off_q    <= '0;
      aud_q        <= 1'b0;
      result_valid <= 1'b0;
      is_hdmi      <= 1'b0;
      has_audio    <= 1'b0;
    end else begin
      if (in_valid && in_idx == IDX_W'(TAG_IDX))  tag_ok_q  <= (in_byte == EXT_TAG);
      if (in_valid && in_idx == IDX_W'(END_IDX))  end_off_q <= OFF_W'(in_byte);
      if (in_valid && in_idx == IDX_W'(FEAT_IDX)) aud_q     <= in_byte[AUDIO_BIT];
      result_valid <= frame_end;
      if (frame_end) begin
        is_hdmi   <= found_now;
        has_audio <= found_now && aud_q;
      end
    end
  end

  // R1: a match can only exist in an extension carrying the right tag
  p_match_needs_tag_r1: assert property (@(posedge clk) disable iff (rst)
    found_q |-> tag_ok_q);

  // R3: a match needs a collection that extends past its first header
  p_match_needs_room_r3: assert property (@(posedge clk) disable iff (rst)
    found_q |-> (end_off_q > OFF_W'(FIRST_HDR)));

  // R7: audio is never reported without HDMI
  p_audio_implies_hdmi_r7: assert property (@(posedge clk) disable iff (rst)
    has_audio |-> is_hdmi);

  // R9: the verdict pulse follows the last byte by one cycle, and only it
  p_pulse_after_last_r9: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> result_valid);
  p_no_stray_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> !result_valid);
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(is_hdmi) && $stable(has_audio)));
endmodule

// File: tb/sim_cea_vsdb_scan.sv
`timescale 1ns/1ps
module sim_cea_vsdb_scan;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [6:0] in_idx = '0;
  logic [7:0] in_byte = '0;
  logic       result_valid, is_hdmi, has_audio;

  always #10 clk = ~clk;

  cea_vsdb_scan u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx), .in_byte(in_byte),
    .result_valid(result_valid), .is_hdmi(is_hdmi), .has_audio(has_audio)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R10";
  logic [7:0] fr [128];
  bit exp_valid = 1'b0, exp_hdmi = 1'b0, exp_aud = 1'b0;

  task automatic chk(string req, string what, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Behavioural reference: walk the collection as a software parser would
  task automatic ref_eval(output bit h, output bit a);
    int off, p, t, l;
    h = 0; a = 0;
    if (fr[0] != 8'h02) return;
    off = fr[2];
    if (off <= 4) return;
    p = 4;
    while (p < off && p < 128) begin
      t = fr[p][7:5];
      l = fr[p][4:0];
      if (p + l + 1 > off) break;
      if (t == 3 && l >= 5 && p + 3 < 128 &&
          fr[p+1] == 8'h03 && fr[p+2] == 8'h0C && fr[p+3] == 8'h00) begin
        h = 1; a = fr[3][6];
        return;
      end
      p += 1 + l;
    end
  endtask

  // one clock: check outputs of the last edge, then drive the next inputs
  task automatic step(bit v, int idx, logic [7:0] b);
    @(negedge clk);
    chk(cur_req, "result_valid", result_valid, exp_valid);
    chk(cur_req, "is_hdmi", is_hdmi, exp_hdmi);
    chk(cur_req, "has_audio", has_audio, exp_aud);
    in_valid = v; in_idx = 7'(idx); in_byte = b;
    exp_valid = v && (idx == 127);
    if (exp_valid) ref_eval(exp_hdmi, exp_aud);
  endtask

  task automatic base(int end_off, bit aud);
    for (int i = 0; i < 128; i++) fr[i] = 8'((i * 37 + 11) & 8'hFF);
    for (int i = 4; i < 128; i++) if (i < end_off) fr[i] = 8'h00;
    fr[0] = 8'h02; fr[1] = 8'h03; fr[2] = 8'(end_off);
    fr[3] = aud ? 8'h40 : 8'h00;
  endtask

  task automatic blk(int p, int tag, int len);
    fr[p] = 8'((tag << 5) | len);
  endtask

  task automatic vsdb(int p, int len, logic [7:0] o1, logic [7:0] o2, logic [7:0] o3);
    blk(p, 3, len);
    fr[p+1] = o1; fr[p+2] = o2; fr[p+3] = o3;
  endtask

  task automatic send(string req, int gap, bit want_h, bit want_a);
    bit h, a;
    cur_req = req;
    ref_eval(h, a);
    chk(req, "model verdict hdmi", h, want_h);
    chk(req, "model verdict audio", a, want_a);
    for (int i = 0; i < 128; i++) begin
      if (gap != 0 && (i % gap) == 1) step(0, i, 8'hA5);
      step(1, i, fr[i]);
    end
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);
    chk(req, "held is_hdmi", is_hdmi, want_h);
    chk(req, "held has_audio", has_audio, want_a);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R10";
    chk("R10", "reset result_valid", result_valid, 1'b0);
    chk("R10", "reset is_hdmi", is_hdmi, 1'b0);
    chk("R10", "reset has_audio", has_audio, 1'b0);
    rst = 1'b0;

    // R6 + R7: HDMI block first, audio set
    base(20, 1); vsdb(4, 5, 8'h03, 8'h0C, 8'h00);
    send("R6", 0, 1, 1);
    // R7: audio bit clear
    base(20, 0); vsdb(4, 6, 8'h03, 8'h0C, 8'h00);
    send("R7", 3, 1, 0);
    // R1: wrong extension tag
    base(20, 1); vsdb(4, 5, 8'h03, 8'h0C, 8'h00); fr[0] = 8'h03;
    send("R1", 0, 0, 0);
    // R3: end offset 4 and 3
    base(4, 1); vsdb(4, 5, 8'h03, 8'h0C, 8'h00);
    send("R3", 0, 0, 0);
    base(3, 1); vsdb(4, 5, 8'h03, 8'h0C, 8'h00);
    send("R3", 5, 0, 0);
    // R4: match after an audio and a video block
    base(40, 1); blk(4, 1, 3); blk(8, 2, 4); vsdb(13, 7, 8'h03, 8'h0C, 8'h00);
    send("R4", 0, 1, 1);
    // R4: OUI bytes placed where a header would be misread if steps were wrong
    base(40, 1); blk(4, 2, 2); vsdb(6, 5, 8'h03, 8'h0C, 8'h00); vsdb(5, 5, 8'h11, 8'h22, 8'h33); blk(4, 2, 1);
    send("R4", 0, 0, 0);
    // R5: block one byte too long
    base(14, 1); blk(4, 1, 2); vsdb(7, 7, 8'h03, 8'h0C, 8'h00);
    send("R5", 0, 0, 0);
    // R5: block ends exactly at the end offset
    base(15, 1); blk(4, 1, 2); vsdb(7, 7, 8'h03, 8'h0C, 8'h00);
    send("R5", 4, 1, 1);
    // R6: length 4 too short
    base(30, 1); vsdb(4, 4, 8'h03, 8'h0C, 8'h00);
    send("R6", 0, 0, 0);
    // R6: OUI in reverse order, then wrong tag
    base(30, 1); vsdb(4, 5, 8'h00, 8'h0C, 8'h03);
    send("R6", 0, 0, 0);
    base(30, 1); vsdb(4, 5, 8'h03, 8'h0C, 8'h00); blk(4, 4, 5);
    send("R6", 0, 0, 0);
    // R2: valid block placed at the end offset
    base(10, 1); blk(4, 1, 5); vsdb(10, 5, 8'h03, 8'h0C, 8'h00);
    send("R2", 0, 0, 0);
    // R8: non-HDMI vendor block then HDMI block
    base(30, 1); vsdb(4, 5, 8'h03, 8'h0C, 8'h01); vsdb(10, 5, 8'h03, 8'h0C, 8'h00);
    send("R8", 0, 1, 1);
    // R8: HDMI block, then an overrunning header that must not clear it
    base(30, 0); vsdb(4, 5, 8'h03, 8'h0C, 8'h00); blk(10, 3, 31);
    send("R8", 2, 1, 0);
    // R9: frame without match directly after a match clears the flags
    base(30, 1);
    send("R9", 0, 0, 0);
    base(30, 1); vsdb(20, 5, 8'h03, 8'h0C, 8'h00);
    send("R9", 0, 1, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule